// File: doc/BRIEF.md
# Dual-Mode Timer Clock Input Filter

This block conditions an asynchronous external timer clock pin so that a counter can use it as a counting source. The pin first passes through a synchronizer chain. A 2-bit mode input then picks two things at run time: the sample enable, and the filter algorithm. The sample enable is either a free-running divide-by-two of the system clock or a channel filter strobe supplied from outside. The algorithm is either two-sample agreement or a saturating up/down integrator.

The block drives the filtered level. It also drives single-cycle rising and falling edge pulses that line up with each change of that level. The mode input comes straight from outside the block; the strobe generator and the counters that use the filtered clock are not part of it.

When the mode changes, the filter state is reloaded from the current synchronized level. This keeps a reconfiguration from counting as a clock edge.

Top module: `tclk_pin_filter`

## Requirements
- R1: While reset is asserted, and after it is released, the filtered level is 0 and both edge pulses are 0 until the filter decides otherwise.
- R2: The pin passes through SYNC_STAGES (default 2) flops before the filter sees it. With a strobe every cycle in two-sample mode, a pin step shows on the filtered level after exactly SYNC_STAGES + 2 rising clock edges.
- R3: Mode value 2'b00 samples on a free-running divide-by-two enable (active every other cycle) and uses two-sample filtering.
- R4: Mode value 2'b01 samples whenever the channel strobe input is 1 and uses two-sample filtering.
- R5: Mode value 2'b10 samples on the divide-by-two enable and uses integrator filtering.
- R6: Mode value 2'b11 samples on the channel strobe and uses integrator filtering.
- R7: In two-sample mode the level takes the sampled value only when the sample agrees with the previous strobed sample. A pin pulse seen by one sample alone is rejected.
- R8: In integrator mode a counter of INT_W bits (default 2) counts up on a high sample and down on a low sample, saturating at 0 and at 2**INT_W-1. The level becomes 1 when the counter reaches the top value and 0 when it reaches 0, and is held in between.
- R9: With the channel strobe low in modes 2'b01 and 2'b11, pin activity does not change the level.
- R10: In the cycle after the mode input changes, the level equals the synchronized pin level, and neither edge pulse is asserted for that change.
- R11: The rise (fall) pulse is high for exactly the one clock cycle in which the level has just gone from 0 to 1 (1 to 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_raw | input | 1 | Asynchronous external timer clock pin |
| chan_strobe | input | 1 | Channel filter sample enable, synchronous to clk |
| mode_sel | input | 2 | Bit 0: strobe source (1 = channel strobe). Bit 1: algorithm (1 = integrator) |
| filt_level | output | 1 | Filtered pin level |
| rise_pulse | output | 1 | One-cycle pulse on a 0-to-1 change of filt_level |
| fall_pulse | output | 1 | One-cycle pulse on a 1-to-0 change of filt_level |

## Verification
The assertions assume that mode_sel and chan_strobe are synchronous to clk. They also assume that the divide-by-two enable never fires on two cycles in a row while the divided source stays selected. The integrator properties assume that a rising level in integrator mode can only come from a counter at its top value. The bench drives every input, including the pin, on the falling clock edge, so all inputs stay synchronous. It changes mode_sel only between test phases, or deliberately in the middle of pin activity to exercise the reload.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
   // Decoded view of the 2-bit mode input
   typedef struct packed {
      logic use_int;   // bit 1: integrator algorithm
      logic use_chan;  // bit 0: channel strobe as sample enable
   } cpf_mode_t;

   function automatic cpf_mode_t cpf_decode(input logic [1:0] m);
      cpf_mode_t r;
      r.use_int  = m[1];
      r.use_chan = m[0];
      return r;
   endfunction
endpackage

// File: rtl/cpf_sync.sv
module cpf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad
         initial $error("cpf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   genvar k;
   generate
      for (k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[k] <= 1'b0;
               else        chain[k] <= chain[k-1];
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cpf_strobe.sv
module cpf_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic use_chan,
   input  logic chan_strobe,
   output logic stb
);
   logic half_q;

   // free-running toggle: enable is high every other system cycle
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) half_q <= 1'b0;
      else        half_q <= ~half_q;

   assign stb = use_chan ? chan_strobe : half_q;

   AST_DIV2_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      (!use_chan && $past(!use_chan) && $past(stb)) |-> !stb); // R3
endmodule

// File: rtl/cpf_filter.sv
module cpf_filter #(
   parameter int INT_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_lvl,
   input  logic stb,
   input  logic use_int,
   input  logic reload,
   output logic level,
   output logic rise,
   output logic fall
);
   localparam logic [INT_W-1:0] CNT_TOP = {INT_W{1'b1}};
   localparam logic [INT_W-1:0] CNT_BOT = '0;

   generate
      if (INT_W < 1 || INT_W > 8) begin : g_bad
         initial $error("cpf_filter: INT_W must be in 1..8");
      end
   endgenerate

   logic             samp_q, samp_d;
   logic [INT_W-1:0] cnt_q, cnt_d;
   logic             lvl_q, lvl_d;
   logic             rise_q, fall_q;

   always_comb begin
      samp_d = samp_q;
      cnt_d  = cnt_q;
      lvl_d  = lvl_q;
      if (reload) begin
         samp_d = sync_lvl;
         cnt_d  = sync_lvl ? CNT_TOP : CNT_BOT;
         lvl_d  = sync_lvl;
      end else if (stb) begin
         samp_d = sync_lvl;
         if (sync_lvl && cnt_q != CNT_TOP)
            cnt_d = cnt_q + 1'b1;
         else if (!sync_lvl && cnt_q != CNT_BOT)
            cnt_d = cnt_q - 1'b1;
         if (use_int) begin
            if (cnt_d == CNT_TOP)      lvl_d = 1'b1;
            else if (cnt_d == CNT_BOT) lvl_d = 1'b0;
         end else if (sync_lvl == samp_q) begin
            lvl_d = sync_lvl;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         samp_q <= 1'b0;
         cnt_q  <= CNT_BOT;
         lvl_q  <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         samp_q <= samp_d;
         cnt_q  <= cnt_d;
         lvl_q  <= lvl_d;
         rise_q <=  lvl_d & ~lvl_q & ~reload;
         fall_q <= ~lvl_d &  lvl_q & ~reload;
      end

   assign level = lvl_q;
   assign rise  = rise_q;
   assign fall  = fall_q;

   AST_RISE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R11
   AST_FALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall); // R11
   AST_RISE_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> (level && !fall)); // R11
   AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (!rise && !fall && level == $past(sync_lvl))); // R10
   AST_NO_STB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb && !reload) |=> $stable(level)); // R9
   AST_INT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (use_int && !reload && !lvl_q && lvl_d) |-> (cnt_d == CNT_TOP)); // R8
endmodule

// File: rtl/tclk_pin_filter.sv
module tclk_pin_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int INT_W       = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_raw,
   input  logic       chan_strobe,
   input  logic [1:0] mode_sel,
   output logic       filt_level,
   output logic       rise_pulse,
   output logic       fall_pulse
);
   import cpf_pkg::*;

   cpf_mode_t  mode;
   logic [1:0] mode_q;
   logic       reload;
   logic       sync_lvl;
   logic       stb;

   assign mode   = cpf_decode(mode_sel);
   assign reload = (mode_sel != mode_q);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mode_q <= 2'b00;
      else        mode_q <= mode_sel;

   cpf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_raw),
      .q_sync  (sync_lvl)
   );

   cpf_strobe u_stb (
      .clk         (clk),
      .rst_n       (rst_n),
      .use_chan    (mode.use_chan),
      .chan_strobe (chan_strobe),
      .stb         (stb)
   );

   cpf_filter #(.INT_W(INT_W)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_lvl (sync_lvl),
      .stb      (stb),
      .use_int  (mode.use_int),
      .reload   (reload),
      .level    (filt_level),
      .rise     (rise_pulse),
      .fall     (fall_pulse)
   );

   AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel[0] && !chan_strobe && !reload) |=> $stable(filt_level)); // R4
   AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_pulse && fall_pulse)); // R11
endmodule

// File: tb/sim_tclk_pin_filter.sv
`timescale 1ns/1ps
module sim_tclk_pin_filter;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin_raw = 1'b0;
   logic chan_strobe = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic filt_level, rise_pulse, fall_pulse;

   always #10 clk = ~clk; // 50 MHz

   tclk_pin_filter u0 (
      .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .chan_strobe(chan_strobe),
      .mode_sel(mode_sel), .filt_level(filt_level),
      .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
   );

   int unsigned n_chk = 0, n_fail = 0, cyc = 0;
   string cur_req = "R1";
   bit cmp_on = 1'b0;

   // behavioural reference model
   int pipe[$];           // synchronizer contents, oldest at front
   int m_lvl, m_rise, m_fall, m_prev, m_cnt, m_half;
   int m_mode;

   task automatic model_reset();
      pipe.delete();
      pipe.push_back(0); pipe.push_back(0);
      m_lvl = 0; m_rise = 0; m_fall = 0; m_prev = 0; m_cnt = 0; m_half = 0; m_mode = 0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else begin
         int s, en, was;
         bit chg;
         s   = pipe[0];
         chg = (int'(mode_sel) != m_mode);
         en  = mode_sel[0] ? int'(chan_strobe) : m_half;
         was = m_lvl;
         if (chg) begin
            m_lvl = s; m_prev = s; m_cnt = s ? 3 : 0;
         end else if (en != 0) begin
            if (s != 0 && m_cnt < 3) m_cnt++;
            else if (s == 0 && m_cnt > 0) m_cnt--;
            if (mode_sel[1]) begin
               if (m_cnt == 3) m_lvl = 1;
               else if (m_cnt == 0) m_lvl = 0;
            end else if (s == m_prev) m_lvl = s;
            m_prev = s;
         end
         m_rise = (!chg && m_lvl == 1 && was == 0) ? 1 : 0;
         m_fall = (!chg && m_lvl == 0 && was == 1) ? 1 : 0;
         m_mode = int'(mode_sel);
         m_half = 1 - m_half;
         void'(pipe.pop_front());
         pipe.push_back(int'(pin_raw));
      end
   end

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (cmp_on && rst_n) begin
         check(cur_req, "level", int'(filt_level), m_lvl);
         check("R11",   "rise",  int'(rise_pulse), m_rise);
         check("R11",   "fall",  int'(fall_pulse), m_fall);
      end
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic random_run(int n, int pin_hold_max, int stb_pct);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if ($urandom_range(pin_hold_max, 0) == 0) pin_raw = ~pin_raw;
         chan_strobe = ($urandom_range(99, 0) < stb_pct);
      end
   endtask

   int pulses;

   initial begin
      step(3);
      // R1: reset state
      check("R1", "level in reset", int'(filt_level), 0);
      check("R1", "rise in reset",  int'(rise_pulse), 0);
      check("R1", "fall in reset",  int'(fall_pulse), 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      step(4);
      check("R1", "level after reset", int'(filt_level), 0);

      // R2: latency with strobe every cycle, two-sample mode
      cur_req = "R2";
      mode_sel = 2'b01; chan_strobe = 1'b1;
      step(6);
      pin_raw = 1'b1;
      step(3);
      check("R2", "level after 3 edges", int'(filt_level), 0);
      step(1);
      check("R2", "level after 4 edges", int'(filt_level), 1);
      check("R2", "rise on change", int'(rise_pulse), 1);
      step(1);
      check("R11", "rise one cycle", int'(rise_pulse), 0);

      // R7: single-sample glitch rejected
      cur_req = "R7";
      pin_raw = 1'b0; step(1); pin_raw = 1'b1;
      step(8);
      check("R7", "glitch rejected", int'(filt_level), 1);

      // R8: integrator saturation, strobe every cycle
      cur_req = "R8";
      mode_sel = 2'b11; chan_strobe = 1'b1; pin_raw = 1'b1;
      step(6);
      pin_raw = 1'b0; step(1); pin_raw = 1'b1; step(1); pin_raw = 1'b0;
      step(2);
      check("R8", "held between limits", int'(filt_level), 1);
      step(6);
      check("R8", "low at zero", int'(filt_level), 0);

      // R9: channel strobe low ignores pin
      cur_req = "R9";
      mode_sel = 2'b01; chan_strobe = 1'b0;
      step(4);
      for (int i = 0; i < 20; i++) begin pin_raw = ~pin_raw; step(1); end
      pin_raw = 1'b1; step(10);
      check("R9", "level held without strobe", int'(filt_level), 0);
      mode_sel = 2'b11; step(1); mode_sel = 2'b11;
      check("R10", "reload takes sync level", int'(filt_level), 1);
      check("R10", "no rise on reload", int'(rise_pulse), 0);

      // R3..R6: random traffic per mode
      cur_req = "R3"; mode_sel = 2'b00; random_run(3000, 3, 50);
      cur_req = "R4"; mode_sel = 2'b01; random_run(3000, 4, 40);
      cur_req = "R5"; mode_sel = 2'b10; random_run(3000, 5, 50);
      cur_req = "R6"; mode_sel = 2'b11; random_run(3000, 6, 60);

      // R10: mode changes during activity, count pulses on reload cycles
      cur_req = "R10";
      pulses = 0;
      for (int i = 0; i < 200; i++) begin
         random_run(7, 2, 50);
         @(negedge clk);
         mode_sel = mode_sel + 2'd1;
         @(negedge clk);
         if (rise_pulse || fall_pulse) pulses++;
      end
      check("R10", "pulses on reload cycles", pulses, 0);

      cmp_on = 1'b0;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule